// File: doc/BRIEF.md
# Matrix Key Change Encoder

The block watches a grid of key switches, up to 8 rows by 12 columns, and turns every change of a key into one byte. A scan strobe from outside marks the moments at which the raw grid is sampled. Each sample is masked by per-row and per-column enables and debounced against the sample before it. The result is then compared with the last state that was reported. Keys whose state differs produce a press or release code, and the codes are queued in a small FIFO that the host drains one byte at a time.

A sample in which three pressed keys sit on three corners of a rectangle cannot be trusted, because the fourth corner may be a phantom closure. Such a sample is dropped as a whole and the reported state is left unchanged. Once the rectangle goes away, the changes are reported against the old state. Apart from that rule, any number of keys may be held together. While codes from one accepted scan are still being moved into the FIFO, further scan strobes are ignored.

Top module: `key_change_encoder`

## Requirements
- R1: A code is bit 7 = direction (0 press, 1 release), bits 6:4 = row index, bits 3:0 = column index plus one; row 0 column 0 gives 0x01/0x81, row 7 column 11 gives 0x7C/0xFC.
- R2: A key whose debounced state equals the last reported state produces no code, so a scan without changes leaves the FIFO empty.
- R3: A key change is accepted only after the key has read the same value on two consecutive accepted scan strobes; after a single strobe nothing is queued.
- R4: A scan whose debounced pressed keys cover three corners of any row/column rectangle queues nothing and keeps the reported state; the changes appear once a later scan is free of such a rectangle.
- R5: Any number of pressed keys that form no such rectangle is reported in full, one code per key.
- R6: A key in a row whose bit in `row_en` is 0, or in a column whose bit in `col_en` is 0, never produces a code.
- R7: Codes from one scan are queued in ascending order of row, then column, at one code per clock.
- R8: `fifo_nempty` is 1 exactly when at least one code is queued; `rd_code` shows the oldest code, a `rd_pop` pulse removes it, and while the queue is empty `rd_code` is 0x00 and a pop has no effect.
- R9: When a code arrives while the 8-entry queue is full (and no pop is made in that cycle), the new code is dropped, the queued codes are kept and `fifo_ovf` becomes 1 and stays 1 until reset.
- R10: After reset the queue is empty, `fifo_ovf` is 0 and `rd_code` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_tick | input | 1 | One-cycle strobe that samples the grid |
| key_raw | input | 96 | Raw grid, bit row*12+col is 1 when the key is closed |
| row_en | input | 8 | Per-row scan enable |
| col_en | input | 12 | Per-column scan enable |
| rd_pop | input | 1 | Removes the oldest queued code |
| rd_code | output | 8 | Oldest queued code, 0x00 when empty |
| fifo_nempty | output | 1 | At least one code is queued |
| fifo_ovf | output | 1 | Sticky flag: a code was dropped because the queue was full |

## Verification
A wrong reported-state register shows up as a missing or doubled press or release code. The bench sees it when it drains the queue after the second strobe of the scenario, and the next scenario repeats the error because every later comparison is made against that state. A faulty rectangle test or debounce register either queues codes that are not expected or leaves the queue empty where codes are due, and this shows within a few clocks of the strobe. Queue pointer and level faults change the order of `rd_code`, the empty read, or the overflow flag when the ninth code is dropped.

// File: rtl/kce_pkg.sv
package kce_pkg;

  typedef logic [7:0] key_code_t;

  function automatic key_code_t kce_code(input logic brk, input logic [2:0] row,
                                         input logic [3:0] col_plus1);
    return {brk, row, col_plus1};
  endfunction

endpackage

// File: rtl/kce_scan.sv
module kce_scan #(
  parameter int NROW = 8,
  parameter int NCOL = 12,
  localparam int NK = NROW * NCOL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_tick,
  input  logic          busy,
  input  logic [NK-1:0] keys_raw,
  input  logic [NROW-1:0] row_en,
  input  logic [NCOL-1:0] col_en,
  output logic [NK-1:0] ref_state,
  output logic [NK-1:0] change_vec,
  output logic          take,
  output logic          ghost_hit,
  output logic          load
);

  logic [NK-1:0] enable_vec;
  logic [NK-1:0] masked;
  logic [NK-1:0] view;
  logic [NK-1:0] prev_q, prev_d;
  logic [NK-1:0] ref_q, ref_d;
  logic [NROW-1:0] row_multi;
  logic [NCOL-1:0] col_multi;
  logic [NK-1:0] corner_vec;

  // enable map per key
  for (genvar r = 0; r < NROW; r++) begin : g_en_r
    for (genvar c = 0; c < NCOL; c++) begin : g_en_c
      assign enable_vec[r*NCOL+c] = row_en[r] & col_en[c];
    end
  end

  assign masked = keys_raw & enable_vec;

  // debounce: accept a bit only when it matches the previous sample
  assign view = (masked & ~(masked ^ prev_q)) | (ref_q & (masked ^ prev_q));

  // a row or column holding more than one pressed key
  for (genvar r = 0; r < NROW; r++) begin : g_rowm
    assign row_multi[r] = ($countones(view[r*NCOL +: NCOL]) > 1);
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_colm
    logic [NROW-1:0] col_slice;
    for (genvar r = 0; r < NROW; r++) begin : g_cs
      assign col_slice[r] = view[r*NCOL+c];
    end
    assign col_multi[c] = ($countones(col_slice) > 1);
  end

  // a pressed key sharing its row and its column with others is a corner
  for (genvar r = 0; r < NROW; r++) begin : g_cor_r
    for (genvar c = 0; c < NCOL; c++) begin : g_cor_c
      assign corner_vec[r*NCOL+c] = view[r*NCOL+c] & row_multi[r] & col_multi[c];
    end
  end

  assign ghost_hit  = |corner_vec;
  assign take       = scan_tick & ~busy;
  assign load       = take & ~ghost_hit;
  assign change_vec = (view ^ ref_q) & enable_vec;

  always_comb begin
    prev_d = prev_q;
    ref_d  = ref_q;
    if (take) begin
      prev_d = masked;
    end
    if (load) begin
      ref_d = view;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      ref_q  <= '0;
    end else begin
      prev_q <= prev_d;
      ref_q  <= ref_d;
    end
  end

  assign ref_state = ref_q;

endmodule

// File: rtl/kce_emit.sv
module kce_emit
  import kce_pkg::*;
#(
  parameter int NROW = 8,
  parameter int NCOL = 12,
  localparam int NK = NROW * NCOL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NK-1:0] change_vec,
  input  logic [NK-1:0] ref_state,
  output logic          busy,
  output logic          push,
  output key_code_t     push_code
);

  logic [NK-1:0] pend_q, pend_d;
  logic [NK-1:0] sel_onehot;
  logic [2:0]    sel_row;
  logic [3:0]    sel_col;
  logic          sel_brk;

  // lowest set index wins: walk downward, last hit stays
  always_comb begin
    sel_onehot = '0;
    sel_row    = '0;
    sel_col    = '0;
    sel_brk    = 1'b0;
    for (int r = NROW - 1; r >= 0; r--) begin
      for (int c = NCOL - 1; c >= 0; c--) begin
        if (pend_q[r*NCOL+c]) begin
          sel_onehot = '0;
          sel_onehot[r*NCOL+c] = 1'b1;
          sel_row = 3'(r);
          sel_col = 4'(c + 1);
          sel_brk = ~ref_state[r*NCOL+c];
        end
      end
    end
  end

  assign busy      = |pend_q;
  assign push      = busy;
  assign push_code = kce_code(sel_brk, sel_row, sel_col);

  always_comb begin
    pend_d = pend_q & ~sel_onehot;
    if (load) begin
      pend_d = change_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/kce_fifo.sv
module kce_fifo #(
  parameter int DEPTH = 8,
  parameter int W = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         nempty,
  output logic         ovf,
  output logic [LW-1:0] level
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          ovf_q, ovf_d;
  logic          full, do_push, do_pop;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (lvl_q == LW'(DEPTH));
  assign nempty  = (lvl_q != '0);
  assign do_pop  = pop & nempty;
  assign do_push = push & (~full | do_pop);

  always_comb begin
    wr_d  = do_push ? ptr_next(wr_q) : wr_q;
    rd_d  = do_pop  ? ptr_next(rd_q) : rd_q;
    lvl_d = lvl_q;
    if (do_push && !do_pop) lvl_d = lvl_q + 1'b1;
    if (!do_push && do_pop) lvl_d = lvl_q - 1'b1;
    ovf_d = ovf_q | (push & ~do_push);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wr_q] <= push_data;
    end
  end

  assign head  = mem[rd_q];
  assign ovf   = ovf_q;
  assign level = lvl_q;

endmodule

// File: rtl/key_change_encoder.sv
module key_change_encoder
  import kce_pkg::*;
#(
  parameter int NROW = 8,
  parameter int NCOL = 12,
  parameter int FIFO_DEPTH = 8,
  localparam int NK = NROW * NCOL,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_tick,
  input  logic [NK-1:0]   key_raw,
  input  logic [NROW-1:0] row_en,
  input  logic [NCOL-1:0] col_en,
  input  logic            rd_pop,
  output logic [7:0]      rd_code,
  output logic            fifo_nempty,
  output logic            fifo_ovf
);

  logic [NK-1:0] ref_state;
  logic [NK-1:0] change_vec;
  logic          scan_take;
  logic          ghost_hit;
  logic          load;
  logic          emit_busy;
  logic          push;
  key_code_t     push_code;
  key_code_t     head;
  logic [LW-1:0] fifo_level;

  kce_scan #(.NROW(NROW), .NCOL(NCOL)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_tick  (scan_tick),
    .busy       (emit_busy),
    .keys_raw   (key_raw),
    .row_en     (row_en),
    .col_en     (col_en),
    .ref_state  (ref_state),
    .change_vec (change_vec),
    .take       (scan_take),
    .ghost_hit  (ghost_hit),
    .load       (load)
  );

  kce_emit #(.NROW(NROW), .NCOL(NCOL)) u_emit (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .change_vec (change_vec),
    .ref_state  (ref_state),
    .busy       (emit_busy),
    .push       (push),
    .push_code  (push_code)
  );

  kce_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_code),
    .pop       (rd_pop),
    .head      (head),
    .nempty    (fifo_nempty),
    .ovf       (fifo_ovf),
    .level     (fifo_level)
  );

  assign rd_code = fifo_nempty ? head : 8'h00;

endmodule

// File: rtl/kce_checker.sv
module kce_checker #(
  parameter int NROW = 8,
  parameter int NCOL = 12,
  parameter int FIFO_DEPTH = 8,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    rd_code,
  input logic          fifo_nempty,
  input logic          fifo_ovf,
  input logic          rd_pop,
  input logic          scan_take,
  input logic          ghost_hit,
  input logic          emit_busy,
  input logic          push,
  input logic [LW-1:0] fifo_level
);

  assert_empty_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_nempty |-> (rd_code == 8'h00));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf |=> fifo_ovf);

  assert_code_fields_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_nempty |-> ((rd_code[3:0] != 4'd0) && (int'(rd_code[3:0]) <= NCOL)
                     && (int'(rd_code[6:4]) < NROW)));

  assert_ghost_queues_nothing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_take && ghost_hit) |=> !emit_busy);

  assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_level) <= FIFO_DEPTH);

  assert_pop_drops_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_nempty && rd_pop && !push) |=> (fifo_level == $past(fifo_level) - 1'b1));

endmodule

bind key_change_encoder kce_checker #(
  .NROW(NROW), .NCOL(NCOL), .FIFO_DEPTH(FIFO_DEPTH)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_code     (rd_code),
  .fifo_nempty (fifo_nempty),
  .fifo_ovf    (fifo_ovf),
  .rd_pop      (rd_pop),
  .scan_take   (scan_take),
  .ghost_hit   (ghost_hit),
  .emit_busy   (emit_busy),
  .push        (push),
  .fifo_level  (fifo_level)
);

// File: tb/key_change_encoder_tb_top.sv
`timescale 1ns/1ps
module key_change_encoder_tb_top;

  localparam int NROW = 8;
  localparam int NCOL = 12;
  localparam int NK = NROW * NCOL;
  localparam int DEPTH = 8;

  logic            clk;
  logic            rst_n;
  logic            scan_tick;
  logic [NK-1:0]   key_raw;
  logic [NROW-1:0] row_en;
  logic [NCOL-1:0] col_en;
  logic            rd_pop;
  logic [7:0]      rd_code;
  logic            fifo_nempty;
  logic            fifo_ovf;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0]    exp_q[$];
  logic [NK-1:0] bref;
  bit            exp_ovf;

  key_change_encoder #(.NROW(NROW), .NCOL(NCOL), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .key_raw(key_raw),
    .row_en(row_en), .col_en(col_en), .rd_pop(rd_pop), .rd_code(rd_code),
    .fifo_nempty(fifo_nempty), .fifo_ovf(fifo_ovf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int kb(input int r, input int c);
    return r * NCOL + c;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) scan_tick = 1'b1;
    @(negedge clk) scan_tick = 1'b0;
    repeat (NK + 4) @(negedge clk);
  endtask

  // reference model: rectangle search written as corner counting
  function automatic bit has_ghost(input logic [NK-1:0] v);
    for (int r1 = 0; r1 < NROW; r1++)
      for (int r2 = r1 + 1; r2 < NROW; r2++)
        for (int c1 = 0; c1 < NCOL; c1++)
          for (int c2 = c1 + 1; c2 < NCOL; c2++) begin
            int n;
            n = v[kb(r1,c1)] + v[kb(r1,c2)] + v[kb(r2,c1)] + v[kb(r2,c2)];
            if (n >= 3) return 1'b1;
          end
    return 1'b0;
  endfunction

  // driver: present a state for two strobes and queue expected codes
  task automatic apply(input logic [NK-1:0] keys);
    logic [NK-1:0] mk;
    key_raw = keys;
    tick();
    tick();
    mk = '0;
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++)
        mk[kb(r,c)] = keys[kb(r,c)] & row_en[r] & col_en[c];
    if (!has_ghost(mk)) begin
      for (int r = 0; r < NROW; r++)
        for (int c = 0; c < NCOL; c++)
          if (mk[kb(r,c)] != bref[kb(r,c)]) begin
            if (exp_q.size() < DEPTH)
              exp_q.push_back({~mk[kb(r,c)], 3'(r), 4'(c + 1)});
            else
              exp_ovf = 1'b1;
          end
      bref = mk;
    end
  endtask

  // monitor: drain the queue and compare against the scoreboard
  task automatic drain(input string tag);
    while (fifo_nempty) begin
      logic [7:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
      check(rd_code === e, tag, rd_code, e);
      rd_pop = 1'b1;
      @(negedge clk) rd_pop = 1'b0;
      @(negedge clk);
    end
    check(exp_q.size() == 0, {tag, " missing codes"}, 0, exp_q.size());
    exp_q.delete();
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NK-1:0] k;
    rst_n = 1'b0; scan_tick = 1'b0; key_raw = '0; rd_pop = 1'b0;
    row_en = '1; col_en = '1; bref = '0; exp_ovf = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check(fifo_nempty == 1'b0, "R10 nempty", fifo_nempty, 0);
    check(fifo_ovf == 1'b0, "R10 ovf", fifo_ovf, 0);
    check(rd_code == 8'h00, "R10 code", rd_code, 0);

    // R1 code format at both corners of the grid
    k = '0; k[kb(0,0)] = 1'b1;
    apply(k);
    check(exp_q.size() > 0 && exp_q[0] == 8'h01, "R1 model 0x01", exp_q.size() > 0 ? exp_q[0] : 0, 8'h01);
    check(rd_code == 8'h01, "R1 make r0c0", rd_code, 8'h01);
    drain("R1");
    apply('0);
    check(rd_code == 8'h81, "R1 break r0c0", rd_code, 8'h81);
    drain("R1");
    k = '0; k[kb(7,11)] = 1'b1;
    apply(k);
    check(rd_code == 8'h7C, "R1 make r7c11", rd_code, 8'h7C);
    drain("R1");
    apply('0);
    check(rd_code == 8'hFC, "R1 break r7c11", rd_code, 8'hFC);
    drain("R1");

    // R3 debounce: one strobe is not enough
    k = '0; k[kb(3,5)] = 1'b1;
    key_raw = k;
    tick();
    check(fifo_nempty == 1'b0, "R3 single strobe", fifo_nempty, 0);
    apply(k);
    check(rd_code == 8'h36, "R3 second strobe", rd_code, 8'h36);
    drain("R3");

    // R2 unchanged state produces nothing
    apply(k);
    check(fifo_nempty == 1'b0, "R2 held key", fifo_nempty, 0);
    apply('0);
    drain("R2");

    // R5 several keys on a diagonal
    k = '0;
    for (int i = 0; i < 5; i++) k[kb(i,i)] = 1'b1;
    apply(k);
    drain("R5");
    apply('0);
    drain("R5");

    // R4 three corners of a rectangle
    k = '0; k[kb(0,0)] = 1'b1; k[kb(0,1)] = 1'b1; k[kb(1,0)] = 1'b1;
    apply(k);
    check(fifo_nempty == 1'b0, "R4 ghost scan", fifo_nempty, 0);
    k[kb(0,1)] = 1'b0;
    apply(k);
    drain("R4");
    apply('0);
    drain("R4");

    // R6 masked lines
    row_en[2] = 1'b0; col_en[7] = 1'b0;
    k = '0; k[kb(2,3)] = 1'b1; k[kb(1,3)] = 1'b1; k[kb(4,7)] = 1'b1; k[kb(5,5)] = 1'b1;
    apply(k);
    check(exp_q.size() == 2, "R6 model count", exp_q.size(), 2);
    drain("R6");
    apply('0);
    drain("R6");
    row_en = '1; col_en = '1;
    apply('0);
    drain("R6");

    // R7 ordering
    k = '0; k[kb(6,1)] = 1'b1; k[kb(0,9)] = 1'b1; k[kb(6,0)] = 1'b1;
    apply(k);
    drain("R7");
    apply('0);
    drain("R7");

    // R8 pop while empty
    rd_pop = 1'b1;
    @(negedge clk) rd_pop = 1'b0;
    check(rd_code == 8'h00, "R8 empty code", rd_code, 0);
    check(fifo_nempty == 1'b0, "R8 empty flag", fifo_nempty, 0);
    check(fifo_ovf == 1'b0, "R8 no side effect", fifo_ovf, 0);

    // R9 overflow: nine presses in one row
    k = '0;
    for (int c = 0; c < 9; c++) k[kb(0,c)] = 1'b1;
    apply(k);
    check(exp_ovf == 1'b1, "R9 model ovf", exp_ovf, 1);
    check(fifo_ovf == 1'b1, "R9 ovf set", fifo_ovf, 1);
    drain("R9");
    check(fifo_ovf == 1'b1, "R9 ovf sticky", fifo_ovf, 1);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule